// File: doc/BRIEF.md
# Key Code Serial Bit Sender

This block takes a 4-bit key code from a scanned keypad and sends it out on one serial line, one bit per baud period. It keeps the most recent nonzero code in a holding register, so the code is still there after the key goes back to zero. While a key is down, the bit counter stays at its first position. Sending starts when the key is released. A frame has four data bits, most significant first, then one stop bit at logic 1. There is no start bit.

The baud period comes from the system clock through a divider of `CLK_HZ / BAUD` cycles. When no frame is running, the line rests at 1 and the busy flag is low. A new key press in the middle of a frame drops that frame and starts again from the first bit.

Top module: `keycode_serial_sender`

## Requirements
- R1: After reset the line is 1, busy is 0 and the held code is 0. A press with key code 0 as the first event then sends four 0 data bits and a 1 stop bit.
- R2: A nonzero key code is copied into the held code on the next clock edge. A key code of 0 leaves the held code unchanged.
- R3: A frame has five bit slots in this order: held code bit 3, bit 2, bit 1, bit 0, then a stop bit of 1.
- R4: After release, each data slot lasts exactly `CLK_HZ / BAUD` clock cycles. Slot k (k = 0..3) is on the line after rising edges k·D through (k+1)·D−1 counted from the release, where D is the divider.
- R5: On every cycle with key-active sampled high, the bit index goes to slot 0. The line then shows bit 3 of the held code and busy is 1, and both stay that way until release.
- R6: Once the stop slot is reached the line stays at 1 and busy stays at 0 until the next key press.
- R7: Busy is 1 exactly while a data slot (0..3) is on the line.
- R8: A key press during a frame abandons it. The divider is cleared, and after release the new frame keeps the full R4 timing from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| keyCode | input | 4 | Binary code of the pressed key, 0 when none |
| keyActive | input | 1 | High while any keypad row is active |
| serialOut | output | 1 | Serial line, idle and stop level 1 |
| busy | output | 1 | High while a data bit is being sent |

## Verification
Random frames pick all sixteen codes and hold the key for between one and five cycles. The line is compared against the expected slot on every cycle after release, so a wrong bit order and a slot one cycle too short or too long both show up. Directed cases cover four situations:
- a code-0 press straight after reset, which separates a cleared holding register from a stale one;
- a code-0 press after a real code, which tells retention apart from reloading;
- a press in the middle of a frame, which exposes a divider that is not cleared on restart;
- a long idle wait after the stop slot, which shows whether the counter wraps instead of parking at the stop slot.

// File: rtl/kss_pkg.sv
package kss_pkg;

  // Strobes the control sends to the datapath each cycle.
  typedef struct packed {
    logic loadCode;    // copy the incoming key code into the holding register
    logic clearFrame;  // force the bit index back to slot 0
    logic stepBit;     // move to the next slot
  } kssStrobes_t;

endpackage

// File: rtl/kss_control.sv
module kss_control
  import kss_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int DIV    = 1000,
  localparam int DIV_W = $clog2(DIV + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              keyActive,
  input  logic [CODE_W-1:0] keyCode,
  input  logic [CODE_W-1:0] heldCode,
  input  logic              frameDone,
  output kssStrobes_t       strobes,
  output logic [DIV_W-1:0]  divCnt
);

  logic divWrap;
  logic newCode;

  assign divWrap = (divCnt == DIV_W'(DIV - 1));
  assign newCode = (keyCode != '0) && (keyCode != heldCode);

  // Baud divider: runs only during a frame and is cleared by a key press.
  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
    end else if (keyActive || frameDone) begin
      divCnt <= '0;
    end else if (divWrap) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.loadCode   = newCode;
    strobes.clearFrame = keyActive;
    strobes.stepBit    = !keyActive && !frameDone && divWrap;
  end

endmodule

// File: rtl/kss_datapath.sv
module kss_datapath
  import kss_pkg::*;
#(
  parameter int CODE_W = 4,
  localparam int IDX_W = $clog2(CODE_W + 1),
  localparam int STOP_IDX = CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] keyCode,
  input  kssStrobes_t       strobes,
  output logic [CODE_W-1:0] heldCode,
  output logic [IDX_W-1:0]  bitIdx,
  output logic              frameDone,
  output logic              lineBit
);

  // Holding register for the last nonzero code.
  always_ff @(posedge clk) begin
    if (rst) begin
      heldCode <= '0;
    end else if (strobes.loadCode) begin
      heldCode <= keyCode;
    end
  end

  // Slot counter: parks at the stop slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      bitIdx <= IDX_W'(STOP_IDX);
    end else if (strobes.clearFrame) begin
      bitIdx <= '0;
    end else if (strobes.stepBit) begin
      bitIdx <= bitIdx + IDX_W'(1);
    end
  end

  assign frameDone = (bitIdx == IDX_W'(STOP_IDX));

  // Slot selector: slot i carries code bit CODE_W-1-i, anything else is the stop level.
  logic [CODE_W-1:0] slotHit;
  genvar gi;
  generate
    for (gi = 0; gi < CODE_W; gi++) begin : gSlot
      assign slotHit[gi] = (bitIdx == IDX_W'(gi)) && heldCode[CODE_W-1-gi];
    end
  endgenerate

  always_comb begin
    lineBit = frameDone ? 1'b1 : (|slotHit);
  end

endmodule

// File: rtl/keycode_serial_sender.sv
module keycode_serial_sender
  import kss_pkg::*;
#(
  parameter int CLK_HZ = 100000,
  parameter int BAUD   = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] keyCode,
  input  logic       keyActive,
  output logic       serialOut,
  output logic       busy
);

  localparam int CODE_W = 4;
  localparam int DIV    = CLK_HZ / BAUD;
  localparam int DIV_W  = $clog2(DIV + 1);
  localparam int IDX_W  = $clog2(CODE_W + 1);

  kssStrobes_t       strobes;
  logic [CODE_W-1:0] heldCode;
  logic [IDX_W-1:0]  bitIdx;
  logic [DIV_W-1:0]  divCnt;
  logic              frameDone;
  logic              lineBit;

  kss_control #(.CODE_W(CODE_W), .DIV(DIV)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .keyActive (keyActive),
    .keyCode   (keyCode),
    .heldCode  (heldCode),
    .frameDone (frameDone),
    .strobes   (strobes),
    .divCnt    (divCnt)
  );

  kss_datapath #(.CODE_W(CODE_W)) uData (
    .clk       (clk),
    .rst       (rst),
    .keyCode   (keyCode),
    .strobes   (strobes),
    .heldCode  (heldCode),
    .bitIdx    (bitIdx),
    .frameDone (frameDone),
    .lineBit   (lineBit)
  );

  assign serialOut = lineBit;
  assign busy      = !frameDone;

endmodule

// File: rtl/kss_checks.sv
module kss_checks #(
  parameter int CODE_W = 4,
  parameter int DIV    = 1000,
  localparam int DIV_W = $clog2(DIV + 1),
  localparam int IDX_W = $clog2(CODE_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              keyActive,
  input logic [CODE_W-1:0] keyCode,
  input logic              serialOut,
  input logic              busy,
  input logic [CODE_W-1:0] heldCode,
  input logic [IDX_W-1:0]  bitIdx,
  input logic [DIV_W-1:0]  divCnt
);

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> serialOut);

  assert_idle_stays_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !keyActive) |=> !busy);

  assert_press_slot0_R5: assert property (@(posedge clk) disable iff (rst)
    keyActive |=> (busy && bitIdx == '0));

  assert_keep_code_R2: assert property (@(posedge clk) disable iff (rst)
    (keyCode == '0) |=> (heldCode == $past(heldCode)));

  assert_load_code_R2: assert property (@(posedge clk) disable iff (rst)
    (keyCode != '0) |=> (heldCode == $past(keyCode)));

  assert_slot_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!keyActive && busy) |=>
      (bitIdx == $past(bitIdx) || bitIdx == $past(bitIdx) + IDX_W'(1)));

  assert_div_range_R4: assert property (@(posedge clk) disable iff (rst)
    divCnt < DIV_W'(DIV));

endmodule

bind keycode_serial_sender kss_checks #(.CODE_W(CODE_W), .DIV(DIV)) uChk (
  .clk       (clk),
  .rst       (rst),
  .keyActive (keyActive),
  .keyCode   (keyCode),
  .serialOut (serialOut),
  .busy      (busy),
  .heldCode  (heldCode),
  .bitIdx    (bitIdx),
  .divCnt    (divCnt)
);

// File: tb/sim_keycode_serial_sender.sv
module sim_keycode_serial_sender;

  localparam int CLK_PERIOD = 10;
  localparam int T_CLK_HZ   = 800;
  localparam int T_BAUD     = 100;
  localparam int D          = T_CLK_HZ / T_BAUD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] keyCode = 4'd0;
  logic       keyActive = 1'b0;
  logic       serialOut;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [3:0] modelCode = 4'd0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  keycode_serial_sender #(.CLK_HZ(T_CLK_HZ), .BAUD(T_BAUD)) u0 (
    .clk       (clk),
    .rst       (rst),
    .keyCode   (keyCode),
    .keyActive (keyActive),
    .serialOut (serialOut),
    .busy      (busy)
  );

  function automatic logic expLine(input logic [3:0] code, input int slot);
    if (slot >= 4) return 1'b1;
    return code[3 - slot];
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Press for holdCycles edges, release, then check every cycle of the frame.
  task automatic sendFrame(input logic [3:0] code, input int holdCycles);
    @(negedge clk);
    keyCode   = code;
    keyActive = 1'b1;
    if (code != 4'd0) modelCode = code;
    for (int h = 0; h < holdCycles; h++) begin
      @(negedge clk);
      chk("R5", "held line", serialOut, expLine(modelCode, 0));
      chk("R5", "held busy", busy, 1);
    end
    keyCode   = 4'd0;
    keyActive = 1'b0;
    for (int m = 1; m <= 4 * D + 3; m++) begin
      @(negedge clk);
      chk("R3", $sformatf("line m=%0d", m), serialOut, expLine(modelCode, m / D));
      chk("R7", $sformatf("busy m=%0d", m), busy, (m / D) < 4 ? 1 : 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", "reset line", serialOut, 1);
    chk("R1", "reset busy", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R6", "idle line", serialOut, 1);

    // R1: code 0 first press sends all-zero data
    sendFrame(4'd0, 2);
    // R3/R4 directed patterns
    sendFrame(4'b1000, 1);
    sendFrame(4'b0001, 3);
    sendFrame(4'b1010, 1);
    // R2: code-0 press keeps previous code
    sendFrame(4'd0, 2);

    // R8: restart in mid-frame
    @(negedge clk);
    keyCode = 4'b1101; keyActive = 1'b1; modelCode = 4'b1101;
    @(negedge clk);
    keyCode = 4'd0; keyActive = 1'b0;
    repeat (2 * D + 3) @(negedge clk);
    chk("R8", "mid-frame busy", busy, 1);
    sendFrame(4'b0110, 2);

    // R6: long idle stays at stop level
    repeat (5 * D) @(negedge clk);
    chk("R6", "long idle line", serialOut, 1);
    chk("R6", "long idle busy", busy, 0);

    // Random frames
    for (int n = 0; n < 30; n++) begin
      logic [3:0] c;
      int hold;
      c = 4'($urandom % 16);
      hold = 1 + int'($urandom % 5);
      sendFrame(c, hold);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R4 actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule